// File: doc/BRIEF.md
# Zero-Sequence Offset Selector for a Three-Phase Rectifier

Once per switching period this block picks the common-mode offset that a three-phase rectifier controller adds to all three per-phase voltage references. The offset steers the charge that each phase's DC-link capacitor takes during the period. The phase whose capacitor sits at the highest voltage should receive the least charge, and the phase at the lowest voltage should receive the most. Over successive periods the three capacitor voltages are then pulled together.

A sample enters as three signed references, three phase currents and three measured capacitor voltages. References and capacitor voltages share one fixed-point scale. The block works through these steps:

- It ranks the phases by capacitor voltage and carries each reference and current along with its phase.
- It forms two linear coefficients and two weighted terms.
- It divides each weighted term by its coefficient on one shared serial divider.
- It chooses a candidate offset from a small table driven by the coefficient signs.
- It limits the candidate to the window that keeps every phase in linear modulation.

The upstream controller offers a sample on a valid/ready input and takes the result from a valid/ready output. The block holds one sample at a time. While a sample is in flight `in_ready` stays low and any offered data is left untouched. A finished result stays on `offset` with `out_valid` high until `out_ready` is seen high at a clock edge. Only then does `in_ready` return high.

Top module: `zso_offset_select`

## Requirements
- R1: Phases are ranked by capacitor voltage, from highest to lowest. Equal voltages rank in the order a, b, c, with the lower letter ranked higher. Each phase's reference and current follow its rank. Below, index 0 is the highest rank and index 2 the lowest, with i = current, u = reference and V = capacitor voltage.
- R2: The block forms c1 = i0·V1 − i1·V0, c2 = i1·V2 − i2·V1, w1 = i0·u0·V1 − i1·u1·V0 and w2 = i1·u1·V2 − i2·u2·V1 at full precision. The quotients q1 = w1/c1 and q2 = w2/c2 truncate toward zero and saturate to the 16-bit signed range.
- R3: When c1 > 0 and c2 > 0, the candidate is the larger of q1 and q2.
- R4: When c1 < 0 and c2 < 0, the candidate is the smaller of q1 and q2.
- R5: In the mixed-sign cases the average floor((q1+q2)/2) is chosen when the interval is non-empty, and zero otherwise. For c1 > 0 > c2 the interval is non-empty when q1 < q2 strictly. For c1 < 0 < c2 it is non-empty when q2 < q1 strictly.
- R6: If c1 or c2 equals zero, the candidate is zero.
- R7: The candidate is first raised to the lower bound lo = max over phases of (u − V). It is then lowered to the upper bound hi = min over phases of (u + V), so hi wins when lo > hi. The result is saturated to 16 bits signed.
- R8: `in_ready` is high only while no sample is held, and inputs are captured only on a clock edge with `in_valid` and `in_ready` both high. `out_valid` and `offset` stay unchanged until an edge with `out_ready` high.
- R9: `out_valid` rises within 2·(3·16+1)+10 = 108 cycles of the accepting edge.
- R10: After reset `in_ready` is 1, `out_valid` is 0 and `offset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is offered |
| in_ready | output | 1 | Block can take a sample |
| ref_a | input | 16 | Phase a voltage reference, signed |
| ref_b | input | 16 | Phase b voltage reference, signed |
| ref_c | input | 16 | Phase c voltage reference, signed |
| cur_a | input | 16 | Phase a current, signed |
| cur_b | input | 16 | Phase b current, signed |
| cur_c | input | 16 | Phase c current, signed |
| vdc_a | input | 16 | Phase a capacitor voltage, signed |
| vdc_b | input | 16 | Phase b capacitor voltage, signed |
| vdc_c | input | 16 | Phase c capacitor voltage, signed |
| out_valid | output | 1 | Offset result is present |
| out_ready | input | 1 | Consumer takes the result |
| offset | output | 16 | Selected common-mode offset, signed |

## Verification
The bench targets each branch of the sign table, including the mixed-sign case on both sides of its feasibility test and a zero coefficient that would otherwise feed a meaningless quotient. A design that swapped max and min, inverted the feasibility comparison or used the rounding of an ordinary division for the average would return an offset that differs from the model. It also drives equal capacitor voltages, where a wrong tie rule swaps currents between ranks, and a near-singular coefficient whose quotient must saturate. It drives a window that is empty, where the order of the two clamps decides the answer. Back-pressure is held on the output while new data is offered on the input, which exposes a design that drops the held result or overwrites it with a second sample.

// File: rtl/zso_pkg.sv
`timescale 1ns/1ps
package zso_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_COEF, ST_DIV1, ST_DIV2, ST_SEL, ST_OUT} zso_state_e;
  typedef enum logic [1:0] {PICK_ZERO, PICK_MAX, PICK_MIN, PICK_AVG} zso_pick_e;
endpackage

// File: rtl/zso_sorter.sv
`timescale 1ns/1ps
// Ranks three phases by capacitor voltage (R1), ties broken by lower index first.
module zso_sorter #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] ref_i [3],
  input  logic signed [W-1:0] cur_i [3],
  input  logic signed [W-1:0] vdc_i [3],
  output logic signed [W-1:0] ref_o [3],
  output logic signed [W-1:0] cur_o [3],
  output logic signed [W-1:0] vdc_o [3]
);
  logic [1:0] rank [3];

  always_comb begin
    for (int x = 0; x < 3; x++) begin
      rank[x] = 2'd0;
      for (int j = 0; j < 3; j++) begin
        if (j != x && (vdc_i[j] > vdc_i[x] || (vdc_i[j] == vdc_i[x] && j < x)))
          rank[x] = rank[x] + 2'd1;
      end
    end
    for (int p = 0; p < 3; p++) begin
      ref_o[p] = '0;
      cur_o[p] = '0;
      vdc_o[p] = '0;
      for (int x = 0; x < 3; x++) begin
        if (rank[x] == 2'(p)) begin
          ref_o[p] = ref_i[x];
          cur_o[p] = cur_i[x];
          vdc_o[p] = vdc_i[x];
        end
      end
    end
  end
endmodule

// File: rtl/zso_coef.sv
`timescale 1ns/1ps
// Full-precision coefficient and weighted-term arithmetic (R2).
module zso_coef #(
  parameter int W  = 16,
  parameter int BW = 3*W+1
) (
  input  logic signed [W-1:0]  ref_s [3],
  input  logic signed [W-1:0]  cur_s [3],
  input  logic signed [W-1:0]  vdc_s [3],
  output logic signed [BW-1:0] c1,
  output logic signed [BW-1:0] c2,
  output logic signed [BW-1:0] w1,
  output logic signed [BW-1:0] w2
);
  logic signed [BW-1:0] ie [3];
  logic signed [BW-1:0] ue [3];
  logic signed [BW-1:0] ve [3];

  for (genvar k = 0; k < 3; k++) begin : g_ext
    assign ie[k] = BW'(cur_s[k]);
    assign ue[k] = BW'(ref_s[k]);
    assign ve[k] = BW'(vdc_s[k]);
  end

  assign c1 = ie[0]*ve[1] - ie[1]*ve[0];
  assign c2 = ie[1]*ve[2] - ie[2]*ve[1];
  assign w1 = ie[0]*ue[0]*ve[1] - ie[1]*ue[1]*ve[0];
  assign w2 = ie[1]*ue[1]*ve[2] - ie[2]*ue[2]*ve[1];
endmodule

// File: rtl/zso_divider.sv
`timescale 1ns/1ps
// Restoring serial divider on magnitudes, result truncated toward zero.
module zso_divider #(
  parameter int WIDTH = 49
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic signed [WIDTH-1:0] num,
  input  logic signed [WIDTH-1:0] den,
  output logic                    done,
  output logic signed [WIDTH-1:0] quot
);
  localparam int CW = $clog2(WIDTH+1);

  logic [WIDTH-1:0] qr, dm, nmag, dmag;
  logic [WIDTH:0]   rem, shifted;
  logic [CW-1:0]    cnt;
  logic             neg;

  assign nmag    = num[WIDTH-1] ? $unsigned(-num) : $unsigned(num);
  assign dmag    = den[WIDTH-1] ? $unsigned(-den) : $unsigned(den);
  assign shifted = {rem[WIDTH-1:0], qr[WIDTH-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qr <= '0; dm <= '0; rem <= '0; cnt <= '0; neg <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        qr  <= nmag;
        dm  <= dmag;
        rem <= '0;
        neg <= num[WIDTH-1] ^ den[WIDTH-1];
        cnt <= CW'(WIDTH);
      end else if (cnt != '0) begin
        if (shifted >= {1'b0, dm}) begin
          rem <= shifted - {1'b0, dm};
          qr  <= {qr[WIDTH-2:0], 1'b1};
        end else begin
          rem <= shifted;
          qr  <= {qr[WIDTH-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign quot = neg ? -$signed(qr) : $signed(qr);

  // remainder of a finished division is below the divisor magnitude (R2)
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dm != '0) |-> (rem < {1'b0, dm}));
endmodule

// File: rtl/zso_offset_select.sv
`timescale 1ns/1ps
module zso_offset_select
  import zso_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic signed [W-1:0] ref_a,
  input  logic signed [W-1:0] ref_b,
  input  logic signed [W-1:0] ref_c,
  input  logic signed [W-1:0] cur_a,
  input  logic signed [W-1:0] cur_b,
  input  logic signed [W-1:0] cur_c,
  input  logic signed [W-1:0] vdc_a,
  input  logic signed [W-1:0] vdc_b,
  input  logic signed [W-1:0] vdc_c,
  output logic                out_valid,
  input  logic                out_ready,
  output logic signed [W-1:0] offset
);
  localparam int BW      = 3*W+1;
  localparam int XW      = W+2;
  localparam int LAT_MAX = 2*BW+10;
  localparam int LCW     = $clog2(LAT_MAX+2);
  localparam logic signed [W-1:0] MAXW = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINW = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sat_q(input logic signed [BW-1:0] q);
    if (q > BW'(MAXW))      sat_q = MAXW;
    else if (q < BW'(MINW)) sat_q = MINW;
    else                    sat_q = q[W-1:0];
  endfunction

  function automatic logic signed [W-1:0] sat_x(input logic signed [XW-1:0] q);
    if (q > XW'(MAXW))      sat_x = MAXW;
    else if (q < XW'(MINW)) sat_x = MINW;
    else                    sat_x = q[W-1:0];
  endfunction

  zso_state_e state;
  logic signed [W-1:0]  ref_in [3], cur_in [3], vdc_in [3];
  logic signed [W-1:0]  ref_so [3], cur_so [3], vdc_so [3];
  logic signed [W-1:0]  ref_q [3], cur_q [3], vdc_q [3];
  logic signed [BW-1:0] c1_w, c2_w, w1_w, w2_w;
  logic signed [BW-1:0] c1_q, c2_q, w1_q, w2_q;
  logic signed [BW-1:0] div_q;
  logic signed [W-1:0]  t1, t2;
  logic                 go, second, div_done;
  zso_pick_e            pick;
  logic signed [XW-1:0] e1, e2, avg, cand, lo, hi, clamped;
  logic                 c1_pos, c2_pos, c1_neg, c2_neg;

  assign ref_in[0] = ref_a; assign ref_in[1] = ref_b; assign ref_in[2] = ref_c;
  assign cur_in[0] = cur_a; assign cur_in[1] = cur_b; assign cur_in[2] = cur_c;
  assign vdc_in[0] = vdc_a; assign vdc_in[1] = vdc_b; assign vdc_in[2] = vdc_c;

  zso_sorter #(.W(W)) u_sort (
    .ref_i(ref_in), .cur_i(cur_in), .vdc_i(vdc_in),
    .ref_o(ref_so), .cur_o(cur_so), .vdc_o(vdc_so)
  );

  zso_coef #(.W(W), .BW(BW)) u_coef (
    .ref_s(ref_q), .cur_s(cur_q), .vdc_s(vdc_q),
    .c1(c1_w), .c2(c2_w), .w1(w1_w), .w2(w2_w)
  );

  zso_divider #(.WIDTH(BW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(go),
    .num(second ? w2_q : w1_q), .den(second ? c2_q : c1_q),
    .done(div_done), .quot(div_q)
  );

  assign in_ready = (state == ST_IDLE);

  // case table and linear-modulation window
  always_comb begin
    c1_pos = !c1_q[BW-1] && (c1_q != '0);
    c2_pos = !c2_q[BW-1] && (c2_q != '0);
    c1_neg = c1_q[BW-1];
    c2_neg = c2_q[BW-1];
    e1  = XW'(t1);
    e2  = XW'(t2);
    avg = (e1 + e2) >>> 1;
    if (c1_q == '0 || c2_q == '0)  pick = PICK_ZERO;
    else if (c1_pos && c2_pos)     pick = PICK_MAX;
    else if (c1_neg && c2_neg)     pick = PICK_MIN;
    else if (c1_pos)               pick = (e1 < e2) ? PICK_AVG : PICK_ZERO;
    else                           pick = (e2 < e1) ? PICK_AVG : PICK_ZERO;
    case (pick)
      PICK_MAX: cand = (e1 > e2) ? e1 : e2;
      PICK_MIN: cand = (e1 < e2) ? e1 : e2;
      PICK_AVG: cand = avg;
      default:  cand = '0;
    endcase
    lo = XW'(ref_q[0]) - XW'(vdc_q[0]);
    hi = XW'(ref_q[0]) + XW'(vdc_q[0]);
    for (int k = 1; k < 3; k++) begin
      if (XW'(ref_q[k]) - XW'(vdc_q[k]) > lo) lo = XW'(ref_q[k]) - XW'(vdc_q[k]);
      if (XW'(ref_q[k]) + XW'(vdc_q[k]) < hi) hi = XW'(ref_q[k]) + XW'(vdc_q[k]);
    end
    clamped = (cand < lo) ? lo : cand;
    if (clamped > hi) clamped = hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ref_q <= '{default: '0};
      cur_q <= '{default: '0};
      vdc_q <= '{default: '0};
      c1_q <= '0; c2_q <= '0; w1_q <= '0; w2_q <= '0;
      t1 <= '0; t2 <= '0;
      go <= 1'b0; second <= 1'b0;
      out_valid <= 1'b0; offset <= '0;
    end else begin
      go <= 1'b0;
      case (state)
        ST_IDLE: if (in_valid) begin
          ref_q <= ref_so; cur_q <= cur_so; vdc_q <= vdc_so;
          state <= ST_COEF;
        end
        ST_COEF: begin
          c1_q <= c1_w; c2_q <= c2_w; w1_q <= w1_w; w2_q <= w2_w;
          go <= 1'b1; second <= 1'b0;
          state <= ST_DIV1;
        end
        ST_DIV1: if (div_done) begin
          t1 <= sat_q(div_q);
          go <= 1'b1; second <= 1'b1;
          state <= ST_DIV2;
        end
        ST_DIV2: if (div_done) begin
          t2 <= sat_q(div_q);
          state <= ST_SEL;
        end
        ST_SEL: begin
          offset <= sat_x(clamped);
          out_valid <= 1'b1;
          state <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // latency watch counter for the bound check
  logic [LCW-1:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (state == ST_IDLE) lat <= '0;
    else if (!out_valid && lat != {LCW{1'b1}}) lat <= lat + 1'b1;
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lat <= LCW'(LAT_MAX));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(offset)));

  p_out_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_sorted_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_COEF) |-> (vdc_q[0] >= vdc_q[1] && vdc_q[1] >= vdc_q[2]));

  p_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((lo > hi) ||
      ((XW'(offset) >= lo || lo > XW'(MAXW)) && (XW'(offset) <= hi || hi < XW'(MINW)))));
endmodule

// File: tb/zso_offset_select_test.sv
`timescale 1ns/1ps
module zso_offset_select_test;
  localparam int LAT_BOUND = 2*(3*16+1)+10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic signed [15:0] ref_a = 0, ref_b = 0, ref_c = 0;
  logic signed [15:0] cur_a = 0, cur_b = 0, cur_c = 0;
  logic signed [15:0] vdc_a = 0, vdc_b = 0, vdc_c = 0;
  logic signed [15:0] offset;

  int checks = 0, fails = 0;
  bit finished = 0;
  int gr[3], gc[3], gv[3];

  always #2.5 clk = ~clk;

  zso_offset_select uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c),
    .cur_a(cur_a), .cur_b(cur_b), .cur_c(cur_c),
    .vdc_a(vdc_a), .vdc_b(vdc_b), .vdc_c(vdc_c),
    .out_valid(out_valid), .out_ready(out_ready), .offset(offset)
  );

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint sat16(input longint q);
    if (q > 32767) return 32767;
    if (q < -32768) return -32768;
    return q;
  endfunction

  // mode: 0 zero coefficient, 1 larger, 2 smaller, 3 average, 4 infeasible mixed
  function automatic void model(output longint z, output int mode, output bit clamp_hit);
    int rk[3]; int o[3];
    longint R[3], I[3], U[3];
    longint a1, a2, b1, b2, t1, t2, z0, lo, hi, zc;
    for (int x = 0; x < 3; x++) begin
      rk[x] = 0;
      for (int j = 0; j < 3; j++)
        if (j != x && (gv[j] > gv[x] || (gv[j] == gv[x] && j < x))) rk[x]++;
    end
    for (int x = 0; x < 3; x++) o[rk[x]] = x;
    for (int p = 0; p < 3; p++) begin
      R[p] = gr[o[p]]; I[p] = gc[o[p]]; U[p] = gv[o[p]];
    end
    a1 = I[0]*U[1] - I[1]*U[0];
    a2 = I[1]*U[2] - I[2]*U[1];
    b1 = I[0]*R[0]*U[1] - I[1]*R[1]*U[0];
    b2 = I[1]*R[1]*U[2] - I[2]*R[2]*U[1];
    t1 = (a1 != 0) ? sat16(b1 / a1) : 0;
    t2 = (a2 != 0) ? sat16(b2 / a2) : 0;
    if (a1 == 0 || a2 == 0) begin z0 = 0; mode = 0; end
    else if (a1 > 0 && a2 > 0) begin z0 = (t1 > t2) ? t1 : t2; mode = 1; end
    else if (a1 < 0 && a2 < 0) begin z0 = (t1 < t2) ? t1 : t2; mode = 2; end
    else if (a1 > 0) begin
      if (t1 < t2) begin z0 = (t1 + t2) >>> 1; mode = 3; end else begin z0 = 0; mode = 4; end
    end else begin
      if (t2 < t1) begin z0 = (t1 + t2) >>> 1; mode = 3; end else begin z0 = 0; mode = 4; end
    end
    lo = R[0] - U[0]; hi = R[0] + U[0];
    for (int k = 1; k < 3; k++) begin
      if (R[k] - U[k] > lo) lo = R[k] - U[k];
      if (R[k] + U[k] < hi) hi = R[k] + U[k];
    end
    zc = z0;
    if (zc < lo) zc = lo;
    if (zc > hi) zc = hi;
    clamp_hit = (zc != z0);
    z = sat16(zc);
  endfunction

  task automatic draw(input int want_mode, input int want_clamp, input string tag);
    longint z; int m; bit c; bit ok;
    ok = 0;
    for (int n = 0; n < 20000 && !ok; n++) begin
      for (int k = 0; k < 3; k++) begin
        gr[k] = int'($urandom_range(2000, 0)) - 1000;
        gc[k] = int'($urandom_range(1600, 0)) - 800;
        gv[k] = int'($urandom_range(2500, 400));
      end
      model(z, m, c);
      if ((want_mode < 0 || m == want_mode) && (want_clamp < 0 || int'(c) == want_clamp)) ok = 1;
    end
    check(ok, {tag, " stimulus search"}, 0, 1);
  endtask

  task automatic drive_inputs();
    ref_a = 16'(gr[0]); ref_b = 16'(gr[1]); ref_c = 16'(gr[2]);
    cur_a = 16'(gc[0]); cur_b = 16'(gc[1]); cur_c = 16'(gc[2]);
    vdc_a = 16'(gv[0]); vdc_b = 16'(gv[1]); vdc_c = 16'(gv[2]);
  endtask

  task automatic wait_result(output int lat);
    lat = 1;
    while (!out_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic run_vec(input string tag);
    longint z; int m; bit c; int lat;
    model(z, m, c);
    @(negedge clk);
    drive_inputs();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    wait_result(lat);
    check(lat <= LAT_BOUND, "R9 latency bound", lat, LAT_BOUND);
    check(out_valid && longint'(offset) == z, tag, longint'(offset), z);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic test_reset();
    check(in_ready == 1'b1, "R10 in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    check(offset == 16'sd0, "R10 offset after reset", offset, 0);
  endtask

  task automatic test_both_pos();
    draw(1, 0, "R3");
    run_vec("R3 both coefficients positive picks larger");
  endtask

  task automatic test_both_neg();
    draw(2, 0, "R4");
    run_vec("R4 both coefficients negative picks smaller");
  endtask

  task automatic test_mixed();
    draw(3, 0, "R5");
    run_vec("R5 mixed signs feasible picks floor average");
    draw(3, -1, "R5");
    run_vec("R5 mixed signs feasible second pattern");
    draw(4, -1, "R5");
    run_vec("R5 mixed signs infeasible picks zero");
  endtask

  task automatic test_zero_coef();
    gr[0] = 700; gr[1] = -300; gr[2] = 150;
    gc[0] = 200; gc[1] = 200; gc[2] = -150;
    gv[0] = 2000; gv[1] = 2000; gv[2] = 900;
    run_vec("R6 zero coefficient gives zero candidate");
  endtask

  task automatic test_clamp();
    draw(-1, 1, "R7");
    run_vec("R7 candidate limited to window");
    gr[0] = 3000; gr[1] = -3000; gr[2] = 0;
    gc[0] = 50; gc[1] = -60; gc[2] = 70;
    gv[0] = 500; gv[1] = 600; gv[2] = 700;
    run_vec("R7 empty window upper bound wins");
  endtask

  task automatic test_saturate();
    gr[0] = 5000; gr[1] = -5000; gr[2] = 0;
    gc[0] = 100; gc[1] = 100; gc[2] = 100;
    gv[0] = 3001; gv[1] = 3000; gv[2] = 1000;
    run_vec("R2 near-singular coefficient saturates quotient");
  endtask

  task automatic test_ties();
    for (int n = 0; n < 3; n++) begin
      draw(-1, -1, "R1");
      gv[1] = gv[0];
      if (n == 1) gv[2] = gv[0];
      run_vec("R1 equal capacitor voltages rank by phase order");
    end
  endtask

  task automatic test_random();
    for (int n = 0; n < 6; n++) begin
      draw(-1, -1, "R2");
      run_vec("R2 general sample");
    end
  endtask

  task automatic test_backpressure();
    longint z; int m; bit c; int lat; bit stable_ok; bit busy_ok;
    logic signed [15:0] held;
    draw(-1, -1, "R8");
    model(z, m, c);
    @(negedge clk);
    drive_inputs();
    in_valid = 1'b1;
    @(negedge clk);
    busy_ok = (in_ready == 1'b0);
    // offer a different sample while busy; it must be ignored
    ref_a = 16'sd999; cur_b = -16'sd500; vdc_c = 16'sd2400;
    wait_result(lat);
    busy_ok = busy_ok && (in_ready == 1'b0);
    check(busy_ok, "R8 in_ready low while sample held", in_ready, 0);
    check(longint'(offset) == z, "R8 data offered while busy ignored", longint'(offset), z);
    held = offset;
    stable_ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!out_valid || offset != held) stable_ok = 1'b0;
    end
    check(stable_ok, "R8 result held under back-pressure", offset, held);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R8 result released on out_ready", out_valid, 0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_both_pos();
    test_both_neg();
    test_mixed();
    test_zero_coef();
    test_clamp();
    test_saturate();
    test_ties();
    test_random();
    test_backpressure();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule